// File: doc/BRIEF.md
# Atomic reservation monitor for load-linked / store-conditional

This block guards the read-modify-write sequences of several processor ports that share one memory. A port opens a sequence with a linking load. The monitor then records the 64-byte line that holds the load address and marks that port as holding a reservation. The port closes the sequence with a conditional store. That store reaches memory only if the port's reservation has survived. On success every port's reservation is dropped, so at most one sequence wins. On failure the memory write is held back. One cycle after the request, a registered result strobe carries the outcome (1 for done, 0 for refused) for the port to write into its destination register.

Plain stores are watched too. A store from any port to a reserved line cancels the reservation on that line. Plain loads leave every reservation alone. All ports may issue in the same cycle. The monitor handles them as if they ran one after another, port 0 first, so a lower-numbered port's effect is visible to a higher-numbered one within that cycle. The monitor drives a write enable for each port, and the memory takes its write data and byte lanes directly from the ports.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no port holds a reservation, `rslt_valid` is low, and a conditional store from any port fails.
- R2: A linking load (op code 2'b10) from port p reserves the line `addr[AW-1:6]` for p. A later conditional store (op 2'b11) from p with no intervening cancel drives `store_en[p]` high in its own cycle and returns status 1.
- R3: A conditional store from a port without a live reservation keeps `store_en` for that port low and returns status 0.
- R4: A successful conditional store cancels the reservations of all ports, including ports other than the requester.
- R5: `rslt_valid[p]` is high exactly one cycle after port p presents a conditional store and at no other time. `rslt_status[p]` is 0 whenever `rslt_valid[p]` is low.
- R6: A plain store (op 2'b01) from any port whose address lies in the same 64-byte line as a port's reservation cancels that reservation. A plain store to a different line leaves the reservation in place.
- R7: A second linking load from the same port replaces the recorded line. A store to the earlier line then no longer affects that port.
- R8: Requests in one cycle take effect in ascending port order. A conflict is resolved in favour of the lower-numbered port, whose effect is seen by the higher-numbered ones.
- R9: A plain store always drives its port's `store_en` high in the same cycle. A plain load (op 2'b00) or a linking load never does.
- R10: A plain load to a reserved line leaves every reservation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORT | Request present, one bit per port |
| req_op | input | 2*NPORT | Per-port op code, port p in bits [2p+1:2p]: 00 load, 01 store, 10 linking load, 11 conditional store |
| req_addr | input | NPORT*AW | Per-port byte address, port p in bits [AW*p +: AW] |
| store_en | output | NPORT | Memory write enable per port, same cycle as the request |
| rslt_valid | output | NPORT | Conditional-store result strobe, one cycle after the request |
| rslt_status | output | NPORT | Conditional-store outcome: 1 done, 0 refused |

## Verification
Several functions can act in the same cycle, and the checks focus on two pairs. The first is a conditional store from a low-numbered port arriving together with a conditional store or linking load from a higher-numbered one. The second is a linking load from one port arriving with a plain store to the same line from another port. Directed cycles place these pairs both ways round across the ports. Each outcome is judged by the next conditional store from the affected port. A long pseudo-random sweep then mixes all four op codes over three neighbouring lines on all ports at once. Every write enable and every result is compared with a bench model that applies the requests in port order.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_stage.sv
// One position in the in-cycle ordering chain: applies port IDX's request
// to the reservation state left by all lower-numbered ports.
module llsc_stage #(
  parameter int NPORT = 4,
  parameter int LAW   = 26,
  parameter int IDX   = 0
) (
  input  logic                   req_vld,
  input  logic [1:0]             req_op,
  input  logic [LAW-1:0]         req_line,
  input  logic [NPORT-1:0]       flag_in,
  input  logic [NPORT*LAW-1:0]   line_in,
  output logic [NPORT-1:0]       flag_out,
  output logic [NPORT*LAW-1:0]   line_out,
  output logic                   wr_en,
  output logic                   cond_ok
);
  import llsc_pkg::*;

  llsc_op_e op;
  assign op = llsc_op_e'(req_op);

  always_comb begin
    flag_out = flag_in;
    line_out = line_in;
    wr_en    = 1'b0;
    cond_ok  = 1'b0;
    if (req_vld) begin
      case (op)
        OP_STORE: begin
          wr_en = 1'b1;
          for (int j = 0; j < NPORT; j++) begin
            if (line_in[j*LAW +: LAW] == req_line) flag_out[j] = 1'b0;
          end
        end
        OP_LINK: begin
          flag_out[IDX]             = 1'b1;
          line_out[IDX*LAW +: LAW]  = req_line;
        end
        OP_COND: begin
          if (flag_in[IDX]) begin
            wr_en    = 1'b1;
            cond_ok  = 1'b1;
            flag_out = '0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/llsc_resv_regs.sv
module llsc_resv_regs #(
  parameter int NPORT = 4,
  parameter int LAW   = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [NPORT-1:0]     flag_d,
  input  logic [NPORT*LAW-1:0] line_d,
  output logic [NPORT-1:0]     flag_q,
  output logic [NPORT*LAW-1:0] line_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      line_q <= '0;
    end else if (en) begin
      flag_q <= flag_d;
      line_q <= line_d;
    end
  end
endmodule

// File: rtl/llsc_result_regs.sv
module llsc_result_regs #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] cond_req,
  input  logic [NPORT-1:0] cond_ok,
  output logic [NPORT-1:0] rslt_valid,
  output logic [NPORT-1:0] rslt_status
);
  logic             en;
  logic [NPORT-1:0] valid_d, status_d;

  assign en       = (|cond_req) | (|rslt_valid);
  assign valid_d  = cond_req;
  assign status_d = cond_req & cond_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rslt_valid  <= '0;
      rslt_status <= '0;
    end else if (en) begin
      rslt_valid  <= valid_d;
      rslt_status <= status_d;
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NPORT     = 4,
  parameter int AW        = 32,
  parameter int LINE_BITS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    req_valid,
  input  logic [2*NPORT-1:0]  req_op,
  input  logic [NPORT*AW-1:0] req_addr,
  output logic [NPORT-1:0]    store_en,
  output logic [NPORT-1:0]    rslt_valid,
  output logic [NPORT-1:0]    rslt_status
);
  import llsc_pkg::*;

  localparam int LAW = AW - LINE_BITS;

  logic [NPORT:0][NPORT-1:0]     fchain;
  logic [NPORT:0][NPORT*LAW-1:0] lchain;
  logic [NPORT-1:0]              lock_q;
  logic [NPORT*LAW-1:0]          line_q;
  logic [NPORT-1:0]              cond_req, cond_ok;

  assign fchain[0] = lock_q;
  assign lchain[0] = line_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign cond_req[p] = req_valid[p] && (req_op[2*p +: 2] == OP_COND);

    llsc_stage #(.NPORT(NPORT), .LAW(LAW), .IDX(p)) u_stage (
      .req_vld  (req_valid[p]),
      .req_op   (req_op[2*p +: 2]),
      .req_line (req_addr[p*AW + LINE_BITS +: LAW]),
      .flag_in  (fchain[p]),
      .line_in  (lchain[p]),
      .flag_out (fchain[p+1]),
      .line_out (lchain[p+1]),
      .wr_en    (store_en[p]),
      .cond_ok  (cond_ok[p])
    );
  end

  llsc_resv_regs #(.NPORT(NPORT), .LAW(LAW)) u_resv (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (|req_valid),
    .flag_d (fchain[NPORT]),
    .line_d (lchain[NPORT]),
    .flag_q (lock_q),
    .line_q (line_q)
  );

  llsc_result_regs #(.NPORT(NPORT)) u_rslt (
    .clk         (clk),
    .rst_n       (rst_n),
    .cond_req    (cond_req),
    .cond_ok     (cond_ok),
    .rslt_valid  (rslt_valid),
    .rslt_status (rslt_status)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NPORT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NPORT-1:0]   req_valid,
  input logic [2*NPORT-1:0] req_op,
  input logic [NPORT-1:0]   store_en,
  input logic [NPORT-1:0]   rslt_valid,
  input logic [NPORT-1:0]   rslt_status,
  input logic [NPORT-1:0]   lock_q
);
  logic [NPORT-1:0] sc_req, ll_req, ld_req;

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    assign sc_req[p] = req_valid[p] && (req_op[2*p +: 2] == 2'b11);
    assign ll_req[p] = req_valid[p] && (req_op[2*p +: 2] == 2'b10);
    assign ld_req[p] = req_valid[p] && (req_op[2*p +: 2] == 2'b00);

    // R2
    resv_set_by_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q[p]) |-> $past(ll_req[p]));
  end

  // R5
  result_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sc_req) |=> (rslt_valid == $past(sc_req)));

  // R5
  status_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rslt_status & ~rslt_valid) == '0);

  // R3
  cond_needs_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sc_req & store_en) & ~lock_q) == '0);

  // R4
  win_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(sc_req & store_en)) && !(|ll_req)) |=> (lock_q == '0));

  // R9
  no_write_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ll_req | ld_req) & store_en) == '0);
endmodule

bind llsc_monitor llsc_monitor_chk #(.NPORT(NPORT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .store_en    (store_en),
  .rslt_valid  (rslt_valid),
  .rslt_status (rslt_status),
  .lock_q      (lock_q)
);

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;
  localparam int NP = 4;
  localparam int AW = 32;

  logic             clk;
  logic             rst_n;
  logic [NP-1:0]    req_valid;
  logic [2*NP-1:0]  req_op;
  logic [NP*AW-1:0] req_addr;
  logic [NP-1:0]    store_en, rslt_valid, rslt_status;

  llsc_monitor #(.NPORT(NP), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .store_en(store_en), .rslt_valid(rslt_valid),
    .rslt_status(rslt_status)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  logic            mflag [NP];
  logic [AW-7:0]   mline [NP];
  logic [NP-1:0]   pend_rv, pend_st;

  logic            v [NP];
  logic [1:0]      k [NP];
  logic [AW-1:0]   a [NP];

  task automatic chk(input string tag, input string what, input logic [NP-1:0] act,
                     input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic clear_req();
    for (int i = 0; i < NP; i++) begin v[i] = 0; k[i] = 0; a[i] = 0; end
  endtask

  task automatic step(input string tag);
    logic [NP-1:0] exp_se, rv, st;
    logic [AW-7:0] ln;
    @(negedge clk);
    chk((tag == "") ? "R5" : tag, "rslt_valid", rslt_valid, pend_rv);
    chk((tag == "") ? "R5" : tag, "rslt_status", rslt_status, pend_st);
    for (int i = 0; i < NP; i++) begin
      req_valid[i]         = v[i];
      req_op[2*i +: 2]     = k[i];
      req_addr[i*AW +: AW] = a[i];
    end
    #1;
    exp_se = '0; rv = '0; st = '0;
    for (int i = 0; i < NP; i++) begin
      ln = a[i][AW-1:6];
      if (v[i]) begin
        case (k[i])
          2'b01: begin
            exp_se[i] = 1;
            for (int j = 0; j < NP; j++) if (mflag[j] && mline[j] == ln) mflag[j] = 0;
          end
          2'b10: begin mflag[i] = 1; mline[i] = ln; end
          2'b11: begin
            rv[i] = 1;
            if (mflag[i]) begin
              exp_se[i] = 1; st[i] = 1;
              for (int j = 0; j < NP; j++) mflag[j] = 0;
            end
          end
          default: ;
        endcase
      end
    end
    chk((tag == "") ? "R9" : tag, "store_en", store_en, exp_se);
    pend_rv = rv; pend_st = st;
    clear_req();
  endtask

  task automatic idle(input string tag);
    clear_req();
    step(tag);
  endtask

  logic [31:0] lf;

  initial begin
    rst_n = 0; req_valid = '0; req_op = '0; req_addr = '0;
    for (int i = 0; i < NP; i++) begin mflag[i] = 0; mline[i] = '0; end
    pend_rv = '0; pend_st = '0;
    clear_req();
    repeat (3) @(negedge clk);
    chk("R1", "rslt_valid in reset", rslt_valid, '0);
    chk("R1", "store_en in reset", store_en, '0);
    rst_n = 1;

    // R1: conditional stores on all ports right after reset all fail
    for (int i = 0; i < NP; i++) begin v[i] = 1; k[i] = 2'b11; a[i] = 32'h100 * i; end
    step("R1");
    idle("R1");

    // R2: link then conditional on port 1
    v[1] = 1; k[1] = 2'b10; a[1] = 32'h0000_0100; step("R2");
    v[1] = 1; k[1] = 2'b11; a[1] = 32'h0000_0108; step("R2");
    idle("R2");

    // R3: second conditional without new link fails
    v[1] = 1; k[1] = 2'b11; a[1] = 32'h0000_0100; step("R3");
    idle("R3");

    // R4: winner on port 0 cancels port 2
    v[0] = 1; k[0] = 2'b10; a[0] = 32'h200;
    v[2] = 1; k[2] = 2'b10; a[2] = 32'h300; step("R4");
    v[0] = 1; k[0] = 2'b11; a[0] = 32'h200; step("R4");
    v[2] = 1; k[2] = 2'b11; a[2] = 32'h300; step("R4");
    idle("R4");

    // R6: same-line store cancels; other-line store does not
    v[3] = 1; k[3] = 2'b10; a[3] = 32'h240; step("R6");
    v[0] = 1; k[0] = 2'b01; a[0] = 32'h27F; step("R6");
    v[3] = 1; k[3] = 2'b11; a[3] = 32'h240; step("R6");
    v[3] = 1; k[3] = 2'b10; a[3] = 32'h240; step("R6");
    v[0] = 1; k[0] = 2'b01; a[0] = 32'h280; step("R6");
    v[3] = 1; k[3] = 2'b11; a[3] = 32'h240; step("R6");
    idle("R6");

    // R7: relink moves the reservation
    v[2] = 1; k[2] = 2'b10; a[2] = 32'h400; step("R7");
    v[2] = 1; k[2] = 2'b10; a[2] = 32'h800; step("R7");
    v[1] = 1; k[1] = 2'b01; a[1] = 32'h410; step("R7");
    v[2] = 1; k[2] = 2'b11; a[2] = 32'h800; step("R7");
    idle("R7");

    // R8: same-cycle ordering, lower port first
    v[0] = 1; k[0] = 2'b10; a[0] = 32'h500;
    v[1] = 1; k[1] = 2'b10; a[1] = 32'h600; step("R8");
    v[0] = 1; k[0] = 2'b11; a[0] = 32'h500;
    v[1] = 1; k[1] = 2'b11; a[1] = 32'h600; step("R8");
    v[0] = 1; k[0] = 2'b10; a[0] = 32'h700;
    v[1] = 1; k[1] = 2'b01; a[1] = 32'h720; step("R8");
    v[0] = 1; k[0] = 2'b11; a[0] = 32'h700; step("R8");
    v[0] = 1; k[0] = 2'b01; a[0] = 32'h720;
    v[1] = 1; k[1] = 2'b10; a[1] = 32'h700; step("R8");
    v[1] = 1; k[1] = 2'b11; a[1] = 32'h700;
    v[3] = 1; k[3] = 2'b10; a[3] = 32'h900; step("R8");
    v[3] = 1; k[3] = 2'b11; a[3] = 32'h900; step("R8");
    idle("R8");

    // R10: plain load to a reserved line leaves it intact
    v[1] = 1; k[1] = 2'b10; a[1] = 32'hA00; step("R10");
    v[0] = 1; k[0] = 2'b00; a[0] = 32'hA04;
    v[2] = 1; k[2] = 2'b00; a[2] = 32'hA3C; step("R10");
    v[1] = 1; k[1] = 2'b11; a[1] = 32'hA00; step("R10");
    idle("R10");

    // sweep: all ports, all op codes, three adjacent lines
    lf = 32'h1234_5679;
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < NP; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        v[i] = lf[3] | lf[9];
        k[i] = lf[5:4];
        a[i] = 32'h1000 + 32'(lf[12:11] % 3) * 64 + 32'(lf[20:15]);
      end
      step("");
    end
    idle("R5");
    idle("R5");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule